// File: doc/BRIEF.md
# Dual-Width Integer ALU with Byte-Order Conversion

This block is the arithmetic unit of a 64-bit register machine. On each accepted request it combines a destination register value with a second operand and produces the new destination value. The second operand is either a source register value or a 32-bit immediate. A width select runs the operation either on the full 64 bits or on the low 32 bits. The supported operations are add, subtract, multiply, unsigned divide and remainder, OR, AND, XOR, the three shifts, move, negate and byte-order conversion.

The result is registered. It appears one clock after a request strobe and holds until the next request. Two requests need different handling. One is an unsigned divide or remainder with a zero divisor. The other is a request the unit cannot execute: unused operation codes, a bad conversion width, or conversion in the 64-bit class. For an unexecutable request the unit raises an illegal flag and returns the destination value unchanged.

Top module: `ualu_core`

## Requirements
- R1: The operation code is the 4-bit value `op_code` with these encodings: 0 add, 1 subtract, 2 multiply, 3 unsigned divide, 4 OR, 5 AND, 6 left shift, 7 logical right shift, 8 negate, 9 unsigned remainder, 10 XOR, 11 move, 12 arithmetic right shift, 13 byte-order conversion. Add, subtract and multiply wrap silently at the active width.
- R2: With `src_is_reg` = 1 the second operand is `src_val`. With `src_is_reg` = 0 it is `imm_val`.
- R3: In the 32-bit class (`wide_mode` = 0) an immediate operand is zero-extended. In the 64-bit class (`wide_mode` = 1) it is sign-extended from bit 31.
- R4: In the 32-bit class every operation except byte-order conversion uses only bits 31:0 of each operand, and it returns bits 63:32 as zero.
- R5: OR, AND, XOR and move give the bitwise result, or the second operand for move, at the active width.
- R6: Divide and remainder treat both operands as unsigned. A zero divisor makes divide return zero.
- R7: A zero divisor makes remainder return the dividend. In the 64-bit class that is the whole destination value. In the 32-bit class it is bits 31:0 of the destination with bits 63:32 cleared.
- R8: The shift count is bits 4:0 of the second operand in the 32-bit class and bits 5:0 in the 64-bit class. The arithmetic right shift fills with bit 31 or bit 63 of the destination, depending on the class.
- R9: Negate returns the two's-complement negation of the destination at the active width. It ignores the second operand.
- R10: Byte-order conversion is executed only in the 32-bit class and uses only the destination. `imm_val` selects the width and must be 16, 32 or 64. With `src_is_reg` = 0 the destination is truncated to that width and zero-extended. With `src_is_reg` = 1 the byte order within that width is reversed, and the result is zero-extended.
- R11: Operation codes 14 and 15, a conversion width other than 16, 32 or 64, and a conversion request with `wide_mode` = 1 all set `out_illegal`. In each of these cases `out_value` equals `dst_val`.
- R12: After reset `out_valid`, `out_illegal` and `out_value` are zero. `out_valid` is `in_valid` delayed by one clock. `out_value` and `out_illegal` change only in the cycle after a request and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the operands are sampled on this edge |
| op_code | input | 4 | Operation selector (see R1) |
| src_is_reg | input | 1 | Operand source select; also selects byte order for conversion |
| wide_mode | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm_val | input | 32 | Immediate; also the conversion width |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_value | output | 64 | New destination value |
| out_illegal | output | 1 | Request could not be executed |

## Verification
Every result comes from a single output register. It is therefore due on the first rising edge after `in_valid`, and the bench samples it at the falling edge that follows. At that same falling edge the reference model's prediction for the request is compared with `out_valid`, `out_illegal` and `out_value` together. On idle cycles the model predicts that the previous value and flag are held and that `out_valid` is low. The same per-cycle comparison is therefore made whether or not a request was issued, so a result that arrives late or early is a mismatch.

// File: rtl/ualu_pkg.sv
package ualu_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int IMM_W  = 32;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_MUL   = 4'd2,
        OP_DIV   = 4'd3,
        OP_OR    = 4'd4,
        OP_AND   = 4'd5,
        OP_SHL   = 4'd6,
        OP_SHR   = 4'd7,
        OP_NEG   = 4'd8,
        OP_REM   = 4'd9,
        OP_XOR   = 4'd10,
        OP_MOV   = 4'd11,
        OP_SAR   = 4'd12,
        OP_BSWAP = 4'd13,
        OP_RSV0  = 4'd14,
        OP_RSV1  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_LOGIC = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;

    typedef struct packed {
        alu_op_e             op;
        logic                src_reg;
        logic                wide;
        logic [DATA_W-1:0]   dst;
        logic [DATA_W-1:0]   src;
        logic [IMM_W-1:0]    imm;
    } alu_req_t;

    typedef struct packed {
        logic                illegal;
        logic [DATA_W-1:0]   value;
    } alu_rsp_t;

    // Clear the upper half when operating in the narrow class.
    function automatic logic [DATA_W-1:0] fit_width(input logic [DATA_W-1:0] v,
                                                   input logic wide);
        return wide ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
    endfunction

    // Immediate extension: sign in the wide class, zero in the narrow one.
    function automatic logic [DATA_W-1:0] extend_imm(input logic [IMM_W-1:0] imm,
                                                    input logic wide);
        return wide ? {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm}
                    : {{(DATA_W-IMM_W){1'b0}}, imm};
    endfunction

endpackage

// File: rtl/ualu_opnd.sv
module ualu_opnd
    import ualu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic          src_reg,
    input  logic          wide,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  logic [IW-1:0] imm,
    output logic [DW-1:0] opa,
    output logic [DW-1:0] opb
);
    logic [DW-1:0] raw_b;

    always_comb begin
        raw_b = src_reg ? src : extend_imm(imm, wide);
        opa   = fit_width(dst, wide);
        opb   = fit_width(raw_b, wide);
    end
endmodule

// File: rtl/ualu_shift.sv
module ualu_shift
    import ualu_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int CW = $clog2(DW),
    localparam int HW = DW / 2
) (
    input  shift_kind_e   kind,
    input  logic          wide,
    input  logic [DW-1:0] a,
    input  logic [CW-1:0] amount,
    output logic [DW-1:0] y
);
    logic [CW-1:0] cnt;
    logic [DW-1:0] sext_a;

    always_comb begin
        cnt    = wide ? amount : {1'b0, amount[CW-2:0]};
        sext_a = wide ? a : {{HW{a[HW-1]}}, a[HW-1:0]};
        case (kind)
            SH_LEFT:  y = a << cnt;
            SH_LOGIC: y = a >> cnt;
            SH_ARITH: y = $unsigned($signed(sext_a) >>> cnt);
            default:  y = a;
        endcase
    end
endmodule

// File: rtl/ualu_divmod.sv
module ualu_divmod #(
    parameter int DW = ualu_pkg::DATA_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] quot,
    output logic [DW-1:0] rem
);
    logic zero_div;

    always_comb begin
        zero_div = (b == '0);
        if (zero_div) begin
            quot = '0;
            rem  = a;
        end else begin
            quot = a / b;
            rem  = a % b;
        end
    end
endmodule

// File: rtl/ualu_bswap.sv
module ualu_bswap #(
    parameter int DW = ualu_pkg::DATA_W,
    parameter int IW = ualu_pkg::IMM_W,
    localparam int NW = $clog2(DW / 8)
) (
    input  logic [DW-1:0] val,
    input  logic          big_end,
    input  logic [IW-1:0] width_sel,
    output logic [DW-1:0] y,
    output logic          bad_width
);
    logic [DW-1:0] cand [NW];
    logic [NW-1:0] hit;

    for (genvar k = 0; k < NW; k++) begin : g_width
        localparam int W  = 16 << k;
        localparam int NB = W / 8;
        logic [W-1:0] rev;
        for (genvar j = 0; j < NB; j++) begin : g_byte
            assign rev[8*j +: 8] = val[8*(NB-1-j) +: 8];
        end
        assign cand[k] = big_end ? DW'(rev) : DW'(val[W-1:0]);
        assign hit[k]  = (width_sel == IW'(W));
    end

    always_comb begin
        y = '0;
        for (int k = 0; k < NW; k++) begin
            if (hit[k]) y = cand[k];
        end
        bad_width = ~|hit;
    end
endmodule

// File: rtl/ualu_core.sv
module ualu_core
    import ualu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W,
    localparam int CW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    op_code,
    input  logic          src_is_reg,
    input  logic          wide_mode,
    input  logic [DW-1:0] dst_val,
    input  logic [DW-1:0] src_val,
    input  logic [IW-1:0] imm_val,
    output logic          out_valid,
    output logic [DW-1:0] out_value,
    output logic          out_illegal
);
    alu_op_e       op;
    logic [DW-1:0] opa, opb;
    logic [DW-1:0] sh_y, quot, rem, sw_y;
    logic          sw_bad;
    shift_kind_e   sh_kind;
    alu_rsp_t      nxt;
    logic [DW-1:0] raw;

    assign op = alu_op_e'(op_code);

    ualu_opnd #(.DW(DW), .IW(IW)) u_opnd (
        .src_reg (src_is_reg),
        .wide    (wide_mode),
        .dst     (dst_val),
        .src     (src_val),
        .imm     (imm_val),
        .opa     (opa),
        .opb     (opb)
    );

    always_comb begin
        case (op)
            OP_SHR:  sh_kind = SH_LOGIC;
            OP_SAR:  sh_kind = SH_ARITH;
            default: sh_kind = SH_LEFT;
        endcase
    end

    ualu_shift #(.DW(DW)) u_shift (
        .kind   (sh_kind),
        .wide   (wide_mode),
        .a      (opa),
        .amount (opb[CW-1:0]),
        .y      (sh_y)
    );

    ualu_divmod #(.DW(DW)) u_div (
        .a    (opa),
        .b    (opb),
        .quot (quot),
        .rem  (rem)
    );

    ualu_bswap #(.DW(DW), .IW(IW)) u_swap (
        .val       (dst_val),
        .big_end   (src_is_reg),
        .width_sel (imm_val),
        .y         (sw_y),
        .bad_width (sw_bad)
    );

    always_comb begin
        raw         = dst_val;
        nxt.illegal = 1'b0;
        case (op)
            OP_ADD: raw = opa + opb;
            OP_SUB: raw = opa - opb;
            OP_MUL: raw = opa * opb;
            OP_DIV: raw = quot;
            OP_OR:  raw = opa | opb;
            OP_AND: raw = opa & opb;
            OP_SHL, OP_SHR, OP_SAR: raw = sh_y;
            OP_NEG: raw = '0 - opa;
            OP_REM: raw = rem;
            OP_XOR: raw = opa ^ opb;
            OP_MOV: raw = opb;
            OP_BSWAP: begin
                nxt.illegal = wide_mode | sw_bad;
                raw         = sw_y;
            end
            default: nxt.illegal = 1'b1;
        endcase
        if (nxt.illegal)
            nxt.value = dst_val;
        else if (op == OP_BSWAP)
            nxt.value = raw;
        else
            nxt.value = fit_width(raw, wide_mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_value   <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_value   <= nxt.value;
                out_illegal <= nxt.illegal;
            end
        end
    end
endmodule

// File: rtl/ualu_core_chk.sv
module ualu_core_chk #(
    parameter int DW = 64,
    parameter int IW = 32,
    localparam int HW = DW / 2
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [3:0]    op_code,
    input logic          src_is_reg,
    input logic          wide_mode,
    input logic [DW-1:0] dst_val,
    input logic [DW-1:0] src_val,
    input logic [IW-1:0] imm_val,
    input logic          out_valid,
    input logic [DW-1:0] out_value,
    input logic          out_illegal
);
    // R12
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_value) && $stable(out_illegal)));

    // R11
    reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[3:1] == 3'b111) |=> (out_illegal && out_value == $past(dst_val)));

    // R4
    upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_mode && op_code != 4'hd && op_code[3:1] != 3'b111)
        |=> (out_value[DW-1:HW] == '0 && !out_illegal));

    // R6
    div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'h3 && src_is_reg && src_val == '0) |=> (out_value == '0));

    // R7
    rem_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'h9 && wide_mode && src_is_reg && src_val == '0)
        |=> (out_value == $past(dst_val)));

    // R10
    le16_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code == 4'hd && !wide_mode && !src_is_reg && imm_val == IW'(16))
        |=> (out_value[DW-1:16] == '0 && !out_illegal));
endmodule

bind ualu_core ualu_core_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op_code     (op_code),
    .src_is_reg  (src_is_reg),
    .wide_mode   (wide_mode),
    .dst_val     (dst_val),
    .src_val     (src_val),
    .imm_val     (imm_val),
    .out_valid   (out_valid),
    .out_value   (out_value),
    .out_illegal (out_illegal)
);

// File: tb/ualu_core_test.sv
module ualu_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        src_is_reg = 1'b0;
    logic        wide_mode = 1'b0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm_val = '0;
    logic        out_valid;
    logic [63:0] out_value;
    logic        out_illegal;

    int checks = 0;
    int fails  = 0;
    bit [63:0] last_val = '0;
    bit        last_ill = 1'b0;

    localparam bit [63:0] LOW32 = 64'h0000_0000_FFFF_FFFF;

    always #5 clk = ~clk;

    ualu_core uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .src_is_reg(src_is_reg), .wide_mode(wide_mode), .dst_val(dst_val),
        .src_val(src_val), .imm_val(imm_val), .out_valid(out_valid),
        .out_value(out_value), .out_illegal(out_illegal)
    );

    // Behavioural reference: returns {illegal, value}.
    function automatic bit [64:0] ref_model(int op, bit sreg, bit wide,
                                            bit [63:0] d, bit [63:0] s, bit [31:0] imm);
        bit [63:0] a, b, r;
        int sh, nb;
        bit ill;
        ill = 1'b0;
        r   = d;
        b   = {32'b0, imm};
        if (sreg) b = s;
        else if (wide && imm[31]) b = b | 64'hFFFF_FFFF_0000_0000;
        a = d;
        if (!wide) begin a = a & LOW32; b = b & LOW32; end
        sh = wide ? int'(b % 64) : int'(b % 32);
        case (op)
            0:  r = a + b;
            1:  r = a - b;
            2:  r = a * b;
            3:  r = (b == 0) ? 64'd0 : a / b;
            4:  r = a | b;
            5:  r = a & b;
            6:  r = a << sh;
            7:  r = a >> sh;
            8:  r = 64'd0 - a;
            9:  r = (b == 0) ? a : a % b;
            10: r = a ^ b;
            11: r = b;
            12: begin
                if (wide) r = $unsigned($signed(a) >>> sh);
                else begin
                    bit signed [31:0] t;
                    t = $signed(a[31:0]);
                    t = t >>> sh;
                    r = {32'b0, $unsigned(t)};
                end
            end
            13: begin
                if (wide || !(imm == 16 || imm == 32 || imm == 64)) ill = 1'b1;
                else begin
                    nb = int'(imm) / 8;
                    r  = '0;
                    for (int i = 0; i < nb; i++) begin
                        if (sreg) r[8*i +: 8] = d[8*(nb-1-i) +: 8];
                        else      r[8*i +: 8] = d[8*i +: 8];
                    end
                end
            end
            default: ill = 1'b1;
        endcase
        if (ill) r = d;
        else if (op != 13 && !wide) r = r & LOW32;
        return {ill, r};
    endfunction

    task automatic check(string tag, bit [65:0] got, bit [65:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual v=%0b ill=%0b val=%h expected v=%0b ill=%0b val=%h",
                     tag, got[65], got[64], got[63:0], exp[65], exp[64], exp[63:0]);
        end
    endtask

    // Drive at a falling edge, result registered at the next rising edge,
    // compared at the falling edge after that.
    task automatic step(string tag, bit v, int op, bit sreg, bit wide,
                        bit [63:0] d, bit [63:0] s, bit [31:0] imm);
        bit [64:0] m;
        in_valid = v; op_code = 4'(op); src_is_reg = sreg; wide_mode = wide;
        dst_val = d; src_val = s; imm_val = imm;
        if (v) begin
            m = ref_model(op, sreg, wide, d, s, imm);
            last_ill = m[64];
            last_val = m[63:0];
        end
        @(negedge clk);
        check(tag, {out_valid, out_illegal, out_value}, {v, last_ill, last_val});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", {out_valid, out_illegal, out_value}, 66'd0);
        rst = 1'b0;

        step("R1",  1, 0,  1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0);
        step("R1",  1, 1,  1, 0, 64'd1, 64'd3, 0);
        step("R1",  1, 2,  1, 1, 64'h1_0000_0001, 64'h1_0000_0003, 0);
        step("R2",  1, 0,  0, 1, 64'd10, 64'd999, 32'd5);
        step("R2",  1, 0,  1, 1, 64'd10, 64'd999, 32'd5);
        step("R3",  1, 11, 0, 1, 64'd0, 64'd0, 32'hFFFF_FFF0);
        step("R3",  1, 11, 0, 0, 64'd0, 64'd0, 32'hFFFF_FFF0);
        step("R4",  1, 0,  1, 0, 64'hABCD_0000_FFFF_FFFF, 64'h1234_0000_0000_0001, 0);
        step("R5",  1, 10, 1, 1, 64'hF0F0_0000_1111_2222, 64'h0FF0_0000_1111_0000, 0);
        step("R5",  1, 5,  0, 0, 64'hFFFF_FFFF_1234_5678, 64'd0, 32'h0000_FF00);
        step("R5",  1, 4,  1, 1, 64'h8000_0000_0000_0000, 64'd1, 0);
        step("R6",  1, 3,  1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0);
        step("R6",  1, 3,  0, 1, 64'd100, 64'd0, 32'hFFFF_FFFF);
        step("R6",  1, 3,  1, 1, 64'd77, 64'd0, 0);
        step("R7",  1, 9,  1, 1, 64'h1234_5678_9ABC_DEF0, 64'd0, 0);
        step("R7",  1, 9,  1, 0, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_0000_0000, 0);
        step("R7",  1, 9,  1, 1, 64'd100, 64'd7, 0);
        step("R8",  1, 6,  1, 0, 64'd1, 64'd33, 0);
        step("R8",  1, 6,  1, 1, 64'd1, 64'd65, 0);
        step("R8",  1, 12, 1, 0, 64'h0000_0000_8000_0000, 64'd4, 0);
        step("R8",  1, 12, 1, 1, 64'h8000_0000_0000_0000, 64'd63, 0);
        step("R8",  1, 7,  1, 1, 64'h8000_0000_0000_0000, 64'd63, 0);
        step("R9",  1, 8,  1, 0, 64'd1, 64'd55, 0);
        step("R9",  1, 8,  1, 1, 64'd1, 64'd55, 0);
        step("R10", 1, 13, 0, 0, 64'h1122_3344_5566_7788, 0, 32'd16);
        step("R10", 1, 13, 1, 0, 64'h1122_3344_5566_7788, 0, 32'd16);
        step("R10", 1, 13, 1, 0, 64'h1122_3344_5566_7788, 0, 32'd32);
        step("R10", 1, 13, 1, 0, 64'h1122_3344_5566_7788, 0, 32'd64);
        step("R10", 1, 13, 0, 0, 64'h1122_3344_5566_7788, 0, 32'd64);
        step("R11", 1, 13, 1, 0, 64'h1122_3344_5566_7788, 0, 32'd8);
        step("R11", 1, 13, 1, 1, 64'h1122_3344_5566_7788, 0, 32'd16);
        step("R11", 1, 14, 1, 1, 64'hDEAD_BEEF_0000_0001, 64'd5, 0);
        step("R11", 1, 15, 0, 0, 64'hDEAD_BEEF_0000_0002, 64'd5, 7);
        step("R12", 0, 0,  1, 1, 64'd5, 64'd5, 0);
        step("R12", 0, 3,  1, 0, 64'd9, 64'd0, 0);
        step("R12", 1, 0,  1, 1, 64'd5, 64'd5, 0);

        for (int n = 0; n < 3000; n++) begin
            bit [63:0] d, s;
            bit [31:0] im;
            int op, pick;
            op   = int'($urandom_range(15, 0));
            d    = {$urandom, $urandom};
            s    = {$urandom, $urandom};
            im   = $urandom;
            pick = int'($urandom_range(7, 0));
            if (pick == 0) s = 64'd0;
            if (pick == 1) im = 32'd0;
            if (pick == 2) im = 32'd16 << $urandom_range(2, 0);
            if (pick == 3) s = s & 64'h3F;
            step("R1", ($urandom_range(9, 0) != 0), op, 1'($urandom), 1'($urandom), d, s, im);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule